// File: doc/BRIEF.md
# Cacheline-Boundary Write Burst Splitter

This block sits in the write path of a bus master. It takes one outgoing memory write request and decides how to cut it into bus bursts. The request gives a start address, a length in dwords, the cacheline size and a split-off control bit. Splitting is on when the split-off bit is low. A long write then runs as a plain memory write only up to the first cacheline boundary. The whole cachelines that follow go out as one memory write and invalidate burst. Any remainder shorter than a cacheline goes out as a closing plain memory write.

Each burst leaves the block as a descriptor made of a command code, a dword address and a dword length. Descriptors are offered one at a time over a valid/ready handshake, in rising address order. A request is accepted only while the block reports idle. All request fields are captured on the accepting edge, so the requester may change them afterwards.

The controller has four states:
- IDLE waits for a request.
- LEAD offers the plain write that ends at the first boundary, or the whole burst when no split is made.
- LINES offers the whole-cacheline invalidate burst.
- TAIL offers the closing plain write.

The transitions are:
- IDLE→LEAD on a request whose leading part is non-empty.
- IDLE→LINES on a split request that starts on a boundary.
- LEAD→LINES on acceptance when a split was decided.
- LEAD→IDLE on acceptance of an unsplit burst.
- LINES→TAIL on acceptance when a tail remains.
- LINES→IDLE on acceptance when no tail remains.
- TAIL→IDLE on acceptance.
- A request with a length of zero leaves the block in IDLE.

Top module: `wrburst_splitter`

## Requirements
- R1: With splitting on, a valid line size L and a remainder after the first boundary greater than L, the block emits these descriptors in address order: a plain write from the start address up to the boundary, then an invalidate burst, then a plain write for any tail.
- R2: An invalidate burst starts on an L-aligned address and has a length that is a non-zero multiple of L. It carries all whole lines of the remainder.
- R3: Command code 4'b0111 marks a plain memory write and 4'b1111 a memory write and invalidate. A tail shorter than L is emitted last with code 4'b0111.
- R4: With split_off_i high, the whole request is one plain write of the full length at the start address.
- R5: A line size of 0, or one that is not a power of two, gives one plain write of the full length.
- R6: When the length left after the first boundary is at most L, or the request ends before that boundary, the request is one plain write of the full length.
- R7: A split request that starts on an L-aligned address emits no leading plain write, so its first descriptor is the invalidate burst.
- R8: While desc_valid_o is high and desc_ready_i is low, the command, address and length stay unchanged and valid stays high.
- R9: A start pulse while idle_o is low is ignored and does not change the descriptors of the request in progress.
- R10: A request with a length of 0 emits no descriptor, and the block stays idle.
- R11: After reset, idle_o is high and desc_valid_o is low.
- R12: No descriptor has a length of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request strobe, accepted only while idle |
| addr_i | input | AW (30) | Start dword address |
| count_i | input | CW (16) | Length in dwords |
| line_size_i | input | LW (8) | Cacheline size in dwords |
| split_off_i | input | 1 | High turns splitting off |
| idle_o | output | 1 | Ready for a new request |
| desc_valid_o | output | 1 | Descriptor offered |
| desc_ready_i | input | 1 | Descriptor taken on this edge |
| desc_cmd_o | output | 4 | Command code |
| desc_addr_o | output | AW (30) | Descriptor dword address |
| desc_len_o | output | CW (16) | Descriptor length in dwords |

## Verification
A wrong state or a wrong captured length shows on the descriptor port at the next offered descriptor. It can appear as a missing leading or tail descriptor, an extra one, a wrong command code, or an address that does not continue from the previous length. Because every descriptor of a request is compared in order, such an error is visible within one request, at most three handshakes after the start pulse. A state that fails to return to IDLE shows as idle_o staying low after the last descriptor. A state that fails to hold under back-pressure shows as a field changing during a stall.

// File: rtl/wbs_pkg.sv
package wbs_pkg;
    localparam logic [3:0] CMD_MW  = 4'b0111;
    localparam logic [3:0] CMD_MWI = 4'b1111;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD,
        ST_LINES,
        ST_TAIL
    } wbs_state_e;
endpackage

// File: rtl/wbs_plan.sv
// Combinational split decision: lengths of lead, whole-line and tail parts.
module wbs_plan #(
    parameter int AW = 30,
    parameter int CW = 16,
    parameter int LW = 8
) (
    input  logic [AW-1:0] addr_i,
    input  logic [CW-1:0] count_i,
    input  logic [LW-1:0] line_size_i,
    input  logic          split_off_i,
    output logic [CW-1:0] lead_len_o,
    output logic [CW-1:0] mwi_len_o,
    output logic [CW-1:0] tail_len_o
);
    // addresses are wider than counts; only the low CW bits matter for offsets
    localparam int LOW = (AW < CW) ? AW : CW;

    logic [CW-1:0] line_w, mask, a_lo, offset, to_edge, rest;
    logic          pow2, do_split;

    always_comb begin
        line_w  = CW'(line_size_i);
        mask    = line_w - CW'(1);
        a_lo    = CW'(addr_i[LOW-1:0]);
        pow2    = (line_w & mask) == '0;
        offset  = a_lo & mask;
        to_edge = (offset == '0) ? '0 : (line_w - offset);
        rest    = count_i - to_edge;
        do_split = !split_off_i && (line_w != '0) && pow2
                   && (count_i > to_edge) && (rest > line_w);
        if (do_split) begin
            lead_len_o = to_edge;
            mwi_len_o  = rest & ~mask;
            tail_len_o = rest & mask;
        end else begin
            lead_len_o = count_i;
            mwi_len_o  = '0;
            tail_len_o = '0;
        end
    end
endmodule

// File: rtl/wbs_seq.sv
// Descriptor sequencer: holds the captured plan and walks LEAD, LINES, TAIL.
module wbs_seq
    import wbs_pkg::*;
#(
    parameter int AW = 30,
    parameter int CW = 16,
    parameter int LW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [AW-1:0] addr_i,
    input  logic [CW-1:0] lead_len_i,
    input  logic [CW-1:0] mwi_len_i,
    input  logic [CW-1:0] tail_len_i,
    input  logic [LW-1:0] line_size_i,
    output logic          idle_o,
    output logic          desc_valid_o,
    input  logic          desc_ready_i,
    output logic [3:0]    desc_cmd_o,
    output logic [AW-1:0] desc_addr_o,
    output logic [CW-1:0] desc_len_o
);
    wbs_state_e    state, state_nx;
    logic [AW-1:0] base_q;
    logic [CW-1:0] lead_q, mwi_q, tail_q;
    logic [LW-1:0] line_q;
    logic          accept;

    assign accept = (state == ST_IDLE) && start_i && (lead_len_i != '0 || mwi_len_i != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            lead_q <= '0;
            mwi_q  <= '0;
            tail_q <= '0;
            line_q <= '0;
        end else if (accept) begin
            base_q <= addr_i;
            lead_q <= lead_len_i;
            mwi_q  <= mwi_len_i;
            tail_q <= tail_len_i;
            line_q <= line_size_i;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (accept) state_nx = (lead_len_i != '0) ? ST_LEAD : ST_LINES;
            ST_LEAD:  if (desc_ready_i) state_nx = (mwi_q != '0) ? ST_LINES : ST_IDLE;
            ST_LINES: if (desc_ready_i) state_nx = (tail_q != '0) ? ST_TAIL : ST_IDLE;
            ST_TAIL:  if (desc_ready_i) state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        idle_o       = 1'b0;
        desc_valid_o = 1'b1;
        desc_cmd_o   = CMD_MW;
        desc_addr_o  = base_q;
        desc_len_o   = lead_q;
        unique case (state)
            ST_IDLE: begin
                idle_o       = 1'b1;
                desc_valid_o = 1'b0;
            end
            ST_LEAD: ;
            ST_LINES: begin
                desc_cmd_o  = CMD_MWI;
                desc_addr_o = base_q + AW'(lead_q);
                desc_len_o  = mwi_q;
            end
            ST_TAIL: begin
                desc_addr_o = base_q + AW'(lead_q) + AW'(mwi_q);
                desc_len_o  = tail_q;
            end
        endcase
    end

    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid_o && !desc_ready_i |=> desc_valid_o && $stable(desc_cmd_o)
            && $stable(desc_addr_o) && $stable(desc_len_o));

    // R3
    cmd_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid_o |-> (desc_cmd_o == CMD_MW || desc_cmd_o == CMD_MWI));

    // R2
    mwi_whole_chk: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid_o && desc_cmd_o == CMD_MWI |->
            ((desc_addr_o & (AW'(line_q) - AW'(1))) == '0)
            && ((desc_len_o & (CW'(line_q) - CW'(1))) == '0)
            && (desc_len_o >= CW'(line_q)));

    // R12
    nonzero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid_o |-> desc_len_o != '0);
endmodule

// File: rtl/wrburst_splitter.sv
module wrburst_splitter #(
    parameter int AW = 30,
    parameter int CW = 16,
    parameter int LW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [AW-1:0] addr_i,
    input  logic [CW-1:0] count_i,
    input  logic [LW-1:0] line_size_i,
    input  logic          split_off_i,
    output logic          idle_o,
    output logic          desc_valid_o,
    input  logic          desc_ready_i,
    output logic [3:0]    desc_cmd_o,
    output logic [AW-1:0] desc_addr_o,
    output logic [CW-1:0] desc_len_o
);
    logic [CW-1:0] lead_len, mwi_len, tail_len;

    wbs_plan #(.AW(AW), .CW(CW), .LW(LW)) u_plan (
        .addr_i      (addr_i),
        .count_i     (count_i),
        .line_size_i (line_size_i),
        .split_off_i (split_off_i),
        .lead_len_o  (lead_len),
        .mwi_len_o   (mwi_len),
        .tail_len_o  (tail_len)
    );

    wbs_seq #(.AW(AW), .CW(CW), .LW(LW)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .addr_i       (addr_i),
        .lead_len_i   (lead_len),
        .mwi_len_i    (mwi_len),
        .tail_len_i   (tail_len),
        .line_size_i  (line_size_i),
        .idle_o       (idle_o),
        .desc_valid_o (desc_valid_o),
        .desc_ready_i (desc_ready_i),
        .desc_cmd_o   (desc_cmd_o),
        .desc_addr_o  (desc_addr_o),
        .desc_len_o   (desc_len_o)
    );
endmodule

// File: tb/sim_wrburst_splitter.sv
`timescale 1ns/1ps
module sim_wrburst_splitter;
    localparam int AW = 30;
    localparam int CW = 16;
    localparam int LW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic [CW-1:0] count_i = '0;
    logic [LW-1:0] line_size_i = '0;
    logic          split_off_i = 1'b0;
    logic          idle_o, desc_valid_o;
    logic          desc_ready_i = 1'b0;
    logic [3:0]    desc_cmd_o;
    logic [AW-1:0] desc_addr_o;
    logic [CW-1:0] desc_len_o;

    int tests = 0;
    int fails = 0;

    int exp_n;
    int exp_cmd [3];
    int exp_addr[3];
    int exp_len [3];

    always #2.5 clk = ~clk;

    wrburst_splitter #(.AW(AW), .CW(CW), .LW(LW)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
        .count_i(count_i), .line_size_i(line_size_i), .split_off_i(split_off_i),
        .idle_o(idle_o), .desc_valid_o(desc_valid_o), .desc_ready_i(desc_ready_i),
        .desc_cmd_o(desc_cmd_o), .desc_addr_o(desc_addr_o), .desc_len_o(desc_len_o)
    );

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic push(input int c, input int a, input int l);
        exp_cmd[exp_n]  = c;
        exp_addr[exp_n] = a;
        exp_len[exp_n]  = l;
        exp_n++;
    endtask

    // expected descriptors, derived from R1..R7 and R10
    task automatic model(input int a, input int n, input int ls, input bit off);
        int first_edge, lead, lines, tail;
        bit good;
        exp_n = 0;
        if (n == 0) return;
        good = !off && ls != 0 && ((ls & (ls - 1)) == 0);
        first_edge = good ? ((a + ls - 1) / ls) * ls : a;
        lead = first_edge - a;
        if (good && n > lead && (n - lead) > ls) begin
            lines = ((n - lead) / ls) * ls;
            tail  = n - lead - lines;
            if (lead > 0) push(7, a, lead);
            push(15, first_edge, lines);
            if (tail > 0) push(7, first_edge + lines, tail);
        end else begin
            push(7, a, n);
        end
    endtask

    task automatic run(input string req, input int a, input int n, input int ls,
                       input bit off, input bit stall, input bit inject);
        int got, guard;
        bit prev_stall, injected;
        logic [3:0]    p_cmd;
        logic [AW-1:0] p_addr;
        logic [CW-1:0] p_len;
        model(a, n, ls, off);
        @(negedge clk);
        addr_i = AW'(a); count_i = CW'(n); line_size_i = LW'(ls); split_off_i = off;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        addr_i = '1; count_i = '1; line_size_i = '0; split_off_i = 1'b1;
        got = 0; guard = 0; prev_stall = 0; injected = 0;
        p_cmd = '0; p_addr = '0; p_len = '0;
        while (!idle_o && guard < 100) begin
            start_i = 1'b0;
            desc_ready_i = stall ? ((guard % 3) == 2) : 1'b1;
            if (prev_stall) begin
                // R8 fields held during back-pressure
                check({req, " R8 hold cmd"}, int'(desc_cmd_o), int'(p_cmd));
                check({req, " R8 hold addr"}, int'(desc_addr_o), int'(p_addr));
                check({req, " R8 hold len"}, int'(desc_len_o), int'(p_len));
            end
            if (desc_valid_o && desc_ready_i) begin
                if (got < exp_n) begin
                    check({req, " cmd"}, int'(desc_cmd_o), exp_cmd[got]);
                    check({req, " addr"}, int'(desc_addr_o), exp_addr[got]);
                    check({req, " len"}, int'(desc_len_o), exp_len[got]);
                end
                got++;
            end
            prev_stall = desc_valid_o && !desc_ready_i;
            p_cmd = desc_cmd_o; p_addr = desc_addr_o; p_len = desc_len_o;
            if (inject && prev_stall && !injected) begin
                // R9 start while busy must be ignored
                start_i = 1'b1; addr_i = AW'(1); count_i = CW'(3);
                line_size_i = LW'(4); split_off_i = 1'b0;
                injected = 1;
            end
            guard++;
            @(negedge clk);
        end
        start_i = 1'b0;
        desc_ready_i = 1'b0;
        check({req, " descriptor count"}, got, exp_n);
        check({req, " back to idle"}, int'(idle_o), 1);
    endtask

    task automatic t_reset;
        // R11
        check("R11 idle after reset", int'(idle_o), 1);
        check("R11 no valid after reset", int'(desc_valid_o), 0);
    endtask

    task automatic t_split_tail;    run("R1 R3 lead+lines+tail", 5, 40, 8, 0, 0, 0); endtask
    task automatic t_aligned;       run("R7 aligned start", 16, 20, 8, 0, 0, 0); endtask
    task automatic t_whole_only;    run("R2 lines only", 0, 64, 16, 0, 0, 0); endtask
    task automatic t_short_rest;    run("R6 rest equals line", 3, 13, 8, 0, 0, 0); endtask
    task automatic t_before_edge;   run("R6 ends before edge", 1, 3, 8, 0, 0, 0); endtask
    task automatic t_disabled;      run("R4 split off", 5, 40, 8, 1, 0, 0); endtask
    task automatic t_size_zero;     run("R5 line size 0", 5, 40, 0, 0, 0, 0); endtask
    task automatic t_size_odd;      run("R5 line size 6", 5, 40, 6, 0, 0, 0); endtask
    task automatic t_zero_count;    run("R10 zero length", 9, 0, 8, 0, 0, 0); endtask
    task automatic t_stall_inject;  run("R8 R9 R12 stall+busy start", 2, 30, 4, 0, 1, 1); endtask
    task automatic t_stall_tail;    run("R8 R3 stall with tail", 7, 50, 16, 0, 1, 0); endtask

    initial begin
        #750000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_split_tail();
        t_aligned();
        t_whole_only();
        t_short_rest();
        t_before_edge();
        t_disabled();
        t_size_zero();
        t_size_odd();
        t_zero_count();
        t_stall_inject();
        t_stall_tail();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule